// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an idle-high asynchronous serial line into parallel characters. It runs on the system clock. A one-cycle enable pulse arrives at sixteen times the bit rate, and every timing decision inside the block is counted in these pulses (ticks). A character has a start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit of odd or even sense, then at least one stop bit. Only the first stop bit is checked. The character is placed in an 8-bit holding register, and the block raises a data-ready flag together with parity, framing and overrun flags.

The format comes from a control word. It is latched from the format inputs while the load input is high. The block copies it into the frame logic when a start bit is detected, so a format change made in the middle of a character does not affect that character. A state machine steps through the frame: IDLE, START, DATA, PARITY, STOP and POST.
- IDLE → START on a tick that sees a falling edge of the synchronized line.
- START → IDLE if the line is high again at the mid-start sample (a glitch).
- START → DATA if the line is still low at that sample.
- DATA → PARITY after the last data bit when parity is enabled.
- DATA → STOP after the last data bit when parity is inhibited.
- PARITY → STOP after the parity sample.
- STOP → POST at the stop sample. The holding register is written here.
- POST → IDLE on the next tick. The flags are updated here.

Top module: `serial_rx`

## Requirements
- R1: Reset drives data_ready, parity_err, framing_err and overrun_err low, clears data_out to 0, and sets the control word to 5 bits, odd parity, parity enabled.
- R2: A start is recognised on a falling edge of the line after a two-flop synchronizer. The line is sampled again 8 ticks after detection. If it is high then, the start is a glitch: nothing is transferred and no flag changes.
- R3: Data bits are sampled every 16 ticks after the mid-start sample, least significant bit first. len_sel gives the length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. The result is right-justified in data_out, and the unused upper bits read 0.
- R4: data_out is written at the mid-point sample of the first stop bit. data_ready rises one tick later, about 9 ticks into the stop bit, and never before the middle of the stop bit.
- R5: While dr_clr_n is low, data_ready is driven low on the next clock. This clear takes priority over a new set.
- R6: When parity is enabled, with par_even = 1 for even and 0 for odd, parity_err goes high if the received parity bit gives the wrong sense over the data bits. It stays high until a later character arrives with correct parity.
- R7: With par_inhibit = 1, no parity bit is expected in the frame. parity_err reads low from the cycle after such a control word is loaded.
- R8: framing_err goes high when the first stop bit samples low. It stays high until a later character has a high stop bit. The character is still transferred.
- R9: At each transfer, overrun_err takes the value of data_ready just before the transfer. It is set if data-ready was never cleared, and cleared if data-ready was cleared in the meantime.
- R10: The control word is loaded on every clock while ctrl_load is high. It is copied into the frame logic at start detection, so a change made during a character applies only to later characters.
- R11: The receiver looks for a new start 9 ticks into the first stop bit, so a character whose stop bit is shorter than a full bit is still followed correctly by the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_in | input | 1 | Serial line, idles high |
| ctrl_load | input | 1 | Loads the control word while high |
| len_sel | input | 2 | Character length select |
| par_inhibit | input | 1 | 1 = no parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| dr_clr_n | input | 1 | Active-low clear of data_ready |
| data_out | output | 8 | Holding register, right-justified |
| data_ready | output | 1 | A character is waiting in the holding register |
| parity_err | output | 1 | Parity mismatch on the last checked character |
| framing_err | output | 1 | First stop bit sampled low |
| overrun_err | output | 1 | data_ready was still set when a character was transferred |

## Verification
In the bench a tick is 4 clocks and a bit is 64 clocks. The stop sample falls about 32 to 40 clocks into the first stop bit, after about 2 clocks of synchronizer delay and up to one tick of detection slack. The POST tick adds 4 clocks, so data_ready and the flags are due about 36 to 46 clocks into the stop bit. The bench therefore samples data_ready 16 clocks into the stop bit, where it must still be low, and again at 56 clocks, where it must be high. Data and error checks are made only after the stop bit has ended. A dr_clr_n pulse is checked one clock later, and a control-word load is checked one clock after ctrl_load.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int RX_DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_POST
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_inh;
        logic       par_even;
    } rx_cfg_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '1;
                else     pipe_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '1;
                else     pipe_q <= {pipe_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rx_s,
    input  rx_cfg_t              cfg_in,
    output rx_state_e            state_o,
    output logic                 xfer_o,
    output logic                 done_o,
    output logic [RX_DATA_W-1:0] frame_data_o,
    output logic                 stop_ok_o,
    output logic                 par_err_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(RX_DATA_W);
    localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] END_CNT = CNT_W'(OSR - 1);

    rx_state_e            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 prev_q;
    rx_cfg_t              cfg_q;
    logic [RX_DATA_W-1:0] sh_q;
    logic                 par_bit_q;
    logic                 stop_ok_q;
    logic                 par_err_q;

    logic             fall;
    logic             hit_mid;
    logic             hit_end;
    logic [IDX_W-1:0] last_idx;

    assign fall     = prev_q & ~rx_s;
    assign hit_mid  = (cnt_q == MID_CNT);
    assign hit_end  = (cnt_q == END_CNT);
    assign last_idx = IDX_W'(4) + IDX_W'(cfg_q.len_sel);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_IDLE;
        else     state_q <= state_d;
    end

    // next state and pulses
    always_comb begin
        state_d = state_q;
        xfer_o  = 1'b0;
        done_o  = 1'b0;
        if (tick) begin
            unique case (state_q)
                RX_IDLE: begin
                    if (fall) state_d = RX_START;
                end
                RX_START: begin
                    if (hit_mid) state_d = rx_s ? RX_IDLE : RX_DATA;
                end
                RX_DATA: begin
                    if (hit_end && (idx_q == last_idx))
                        state_d = cfg_q.par_inh ? RX_STOP : RX_PARITY;
                end
                RX_PARITY: begin
                    if (hit_end) state_d = RX_STOP;
                end
                RX_STOP: begin
                    if (hit_end) begin
                        state_d = RX_POST;
                        xfer_o  = 1'b1;
                    end
                end
                RX_POST: begin
                    state_d = RX_IDLE;
                    done_o  = 1'b1;
                end
                default: state_d = RX_IDLE;
            endcase
        end
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            prev_q    <= 1'b1;
            cfg_q     <= '0;
            sh_q      <= '0;
            par_bit_q <= 1'b0;
            stop_ok_q <= 1'b1;
            par_err_q <= 1'b0;
        end else if (tick) begin
            prev_q <= rx_s;
            case (state_q)
                RX_IDLE: begin
                    if (fall) begin
                        cnt_q <= '0;
                        idx_q <= '0;
                        sh_q  <= '0;
                        cfg_q <= cfg_in;
                    end
                end
                RX_START: begin
                    cnt_q <= hit_mid ? '0 : cnt_q + 1'b1;
                end
                RX_DATA: begin
                    if (hit_end) begin
                        cnt_q       <= '0;
                        sh_q[idx_q] <= rx_s;
                        idx_q       <= idx_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (hit_end) begin
                        cnt_q     <= '0;
                        par_bit_q <= rx_s;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (hit_end) begin
                        cnt_q     <= '0;
                        stop_ok_q <= rx_s;
                        par_err_q <= ~cfg_q.par_inh &
                                     ((^sh_q) ^ par_bit_q ^ ~cfg_q.par_even);
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign state_o      = state_q;
    assign frame_data_o = sh_q;
    assign stop_ok_o    = stop_ok_q;
    assign par_err_o    = par_err_q;
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
    import serial_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 xfer,
    input  logic                 done,
    input  logic [RX_DATA_W-1:0] frame_data,
    input  logic                 stop_ok,
    input  logic                 par_err_in,
    input  logic                 par_inh_now,
    input  logic                 dr_clr_n,
    output logic [RX_DATA_W-1:0] hold_o,
    output logic                 dr_o,
    output logic                 pe_o,
    output logic                 fe_o,
    output logic                 oe_o
);
    logic pe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_o <= '0;
            dr_o   <= 1'b0;
            pe_q   <= 1'b0;
            fe_o   <= 1'b0;
            oe_o   <= 1'b0;
        end else begin
            if (xfer) begin
                hold_o <= frame_data;
                oe_o   <= dr_o;
            end
            if (done) begin
                fe_o <= ~stop_ok;
                pe_q <= par_err_in;
            end
            if (!dr_clr_n)  dr_o <= 1'b0;
            else if (done)  dr_o <= 1'b1;
        end
    end

    assign pe_o = pe_q & ~par_inh_now;
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rx_in,
    input  logic       ctrl_load,
    input  logic [1:0] len_sel,
    input  logic       par_inhibit,
    input  logic       par_even,
    input  logic       dr_clr_n,
    output logic [7:0] data_out,
    output logic       data_ready,
    output logic       parity_err,
    output logic       framing_err,
    output logic       overrun_err
);
    rx_cfg_t              ctrl_q;
    logic                 rx_s;
    rx_state_e            fsm_state;
    logic                 xfer;
    logic                 done;
    logic [RX_DATA_W-1:0] frame_data;
    logic                 stop_ok;
    logic                 par_err;

    always_ff @(posedge clk) begin
        if (rst)            ctrl_q <= '0;
        else if (ctrl_load) ctrl_q <= '{len_sel: len_sel, par_inh: par_inhibit,
                                        par_even: par_even};
    end

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rx_in),
        .q   (rx_s)
    );

    rx_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick16),
        .rx_s         (rx_s),
        .cfg_in       (ctrl_q),
        .state_o      (fsm_state),
        .xfer_o       (xfer),
        .done_o       (done),
        .frame_data_o (frame_data),
        .stop_ok_o    (stop_ok),
        .par_err_o    (par_err)
    );

    rx_status_regs u_status (
        .clk         (clk),
        .rst         (rst),
        .xfer        (xfer),
        .done        (done),
        .frame_data  (frame_data),
        .stop_ok     (stop_ok),
        .par_err_in  (par_err),
        .par_inh_now (ctrl_q.par_inh),
        .dr_clr_n    (dr_clr_n),
        .hold_o      (data_out),
        .dr_o        (data_ready),
        .pe_o        (parity_err),
        .fe_o        (framing_err),
        .oe_o        (overrun_err)
    );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk
    import serial_rx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      ctrl_load,
    input logic      par_inhibit,
    input logic      dr_clr_n,
    input logic [7:0] data_out,
    input logic      data_ready,
    input logic      parity_err,
    input logic      framing_err,
    input logic      overrun_err,
    input rx_state_e fsm_state,
    input logic      xfer
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (!data_ready && !parity_err && !framing_err &&
                        !overrun_err && data_out == 8'h00));

    // R3
    hold_write_only_on_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_out) |-> $past(xfer));

    // R4
    ready_after_post_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) |-> $past(fsm_state) == RX_POST);

    // R5
    ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !dr_clr_n |=> !data_ready);

    // R7
    inhibit_masks_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_load && par_inhibit) |=> !parity_err);

    // R8
    framing_after_post_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(framing_err) |-> $past(fsm_state) == RX_POST);

    // R9
    overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_err) |-> $past(data_ready));

    // R9
    overrun_on_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(overrun_err) |-> $past(xfer));
endmodule

bind serial_rx serial_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctrl_load   (ctrl_load),
    .par_inhibit (par_inhibit),
    .dr_clr_n    (dr_clr_n),
    .data_out    (data_out),
    .data_ready  (data_ready),
    .parity_err  (parity_err),
    .framing_err (framing_err),
    .overrun_err (overrun_err),
    .fsm_state   (fsm_state),
    .xfer        (xfer)
);

// File: tb/tb_serial_rx.sv
module tb_serial_rx;
    logic       clk = 1'b0;
    logic       rst;
    logic       tick16;
    logic       rx_in;
    logic       ctrl_load;
    logic [1:0] len_sel;
    logic       par_inhibit;
    logic       par_even;
    logic       dr_clr_n;
    logic [7:0] data_out;
    logic       data_ready;
    logic       parity_err;
    logic       framing_err;
    logic       overrun_err;

    logic [1:0] tdiv = 2'd0;
    int checks = 0;
    int fails  = 0;
    logic dr_early, dr_late;

    localparam int BIT_CLKS = 64;

    always #5 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick16 = (tdiv == 2'd0);

    serial_rx dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_in),
        .ctrl_load(ctrl_load), .len_sel(len_sel), .par_inhibit(par_inhibit),
        .par_even(par_even), .dr_clr_n(dr_clr_n), .data_out(data_out),
        .data_ready(data_ready), .parity_err(parity_err),
        .framing_err(framing_err), .overrun_err(overrun_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic par_of(input logic [7:0] d, input int n, input logic even);
        logic p = 1'b0;
        for (int i = 0; i < n; i++) p ^= d[i];
        return even ? p : ~p;
    endfunction

    task automatic set_ctrl(input logic [1:0] l, input logic inh, input logic ev);
        @(negedge clk);
        len_sel = l; par_inhibit = inh; par_even = ev; ctrl_load = 1'b1;
        @(negedge clk);
        ctrl_load = 1'b0;
    endtask

    task automatic clear_dr;
        @(negedge clk);
        dr_clr_n = 1'b0;
        @(negedge clk);
        dr_clr_n = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] d, input int nbits, input bit pen,
                              input logic pbit, input logic sbit,
                              input int stop_clks, input bit mid_change);
        @(negedge clk);
        rx_in = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rx_in = d[i];
            if (mid_change && i == 2) begin
                len_sel = 2'b00; ctrl_load = 1'b1;
                @(negedge clk);
                ctrl_load = 1'b0;
                repeat (BIT_CLKS - 1) @(negedge clk);
            end else begin
                repeat (BIT_CLKS) @(negedge clk);
            end
        end
        if (pen) begin
            rx_in = pbit;
            repeat (BIT_CLKS) @(negedge clk);
        end
        rx_in = sbit;
        repeat (16) @(negedge clk);
        dr_early = data_ready;
        repeat (40) @(negedge clk);
        dr_late = data_ready;
        rx_in = 1'b1;
        if (stop_clks > 56) repeat (stop_clks - 56) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "data_ready", data_ready, 0);
        chk("R1", "flags", {parity_err, framing_err, overrun_err}, 0);
        chk("R1", "data_out", data_out, 8'h00);
    endtask

    task automatic t_basic;
        set_ctrl(2'b11, 1'b0, 1'b1);
        send_frame(8'hA5, 8, 1, par_of(8'hA5, 8, 1), 1'b1, 64, 0);
        chk("R4", "ready early in stop bit", dr_early, 0);
        chk("R4", "ready late in stop bit", dr_late, 1);
        chk("R3", "8-bit data", data_out, 8'hA5);
        chk("R6", "no parity error", parity_err, 0);
        chk("R8", "no framing error", framing_err, 0);
    endtask

    task automatic t_clear;
        clear_dr();
        chk("R5", "ready cleared", data_ready, 0);
    endtask

    task automatic t_lengths;
        set_ctrl(2'b00, 1'b0, 1'b0);
        send_frame(8'h16, 5, 1, par_of(8'h16, 5, 0), 1'b1, 64, 0);
        chk("R3", "5-bit right-justified", data_out, 8'h16);
        chk("R6", "odd parity ok", parity_err, 0);
        clear_dr();
        set_ctrl(2'b10, 1'b0, 1'b1);
        send_frame(8'h5B, 7, 1, par_of(8'h5B, 7, 1), 1'b1, 64, 0);
        chk("R3", "7-bit data", data_out, 8'h5B);
        clear_dr();
        set_ctrl(2'b01, 1'b0, 1'b1);
        send_frame(8'h2A, 6, 1, par_of(8'h2A, 6, 1), 1'b1, 64, 0);
        chk("R3", "6-bit data", data_out, 8'h2A);
        clear_dr();
    endtask

    task automatic t_parity;
        set_ctrl(2'b11, 1'b0, 1'b0);
        send_frame(8'h3C, 8, 1, ~par_of(8'h3C, 8, 0), 1'b1, 64, 0);
        chk("R6", "parity error set", parity_err, 1);
        clear_dr();
        repeat (100) @(negedge clk);
        chk("R6", "parity error persists", parity_err, 1);
        send_frame(8'h81, 8, 1, par_of(8'h81, 8, 0), 1'b1, 64, 0);
        chk("R6", "parity error cleared by good char", parity_err, 0);
        chk("R6", "data with odd parity", data_out, 8'h81);
        clear_dr();
    endtask

    task automatic t_inhibit;
        send_frame(8'h07, 8, 1, ~par_of(8'h07, 8, 0), 1'b1, 64, 0);
        chk("R6", "parity error before inhibit", parity_err, 1);
        clear_dr();
        set_ctrl(2'b11, 1'b1, 1'b0);
        chk("R7", "inhibit forces parity_err low", parity_err, 0);
        send_frame(8'hC3, 8, 0, 1'b0, 1'b1, 64, 0);
        chk("R7", "frame without parity bit", data_out, 8'hC3);
        chk("R7", "no framing error without parity", framing_err, 0);
        clear_dr();
    endtask

    task automatic t_framing;
        set_ctrl(2'b11, 1'b0, 1'b1);
        send_frame(8'h11, 8, 1, par_of(8'h11, 8, 1), 1'b0, 64, 0);
        repeat (128) @(negedge clk);
        chk("R8", "framing error set", framing_err, 1);
        chk("R8", "char still transferred", data_out, 8'h11);
        clear_dr();
        send_frame(8'h22, 8, 1, par_of(8'h22, 8, 1), 1'b1, 64, 0);
        chk("R8", "framing error cleared", framing_err, 0);
    endtask

    task automatic t_overrun;
        send_frame(8'h33, 8, 1, par_of(8'h33, 8, 1), 1'b1, 64, 0);
        chk("R9", "overrun set", overrun_err, 1);
        chk("R9", "overrun data", data_out, 8'h33);
        clear_dr();
        send_frame(8'h44, 8, 1, par_of(8'h44, 8, 1), 1'b1, 64, 0);
        chk("R9", "overrun cleared", overrun_err, 0);
        clear_dr();
    endtask

    task automatic t_glitch;
        @(negedge clk);
        rx_in = 1'b0;
        repeat (12) @(negedge clk);
        rx_in = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        chk("R2", "glitch gives no ready", data_ready, 0);
        chk("R2", "glitch leaves data", data_out, 8'h44);
        send_frame(8'h55, 8, 1, par_of(8'h55, 8, 1), 1'b1, 64, 0);
        chk("R2", "frame after glitch", data_out, 8'h55);
        clear_dr();
    endtask

    task automatic t_midchange;
        set_ctrl(2'b11, 1'b0, 1'b1);
        send_frame(8'h96, 8, 1, par_of(8'h96, 8, 1), 1'b1, 64, 1);
        chk("R10", "mid-char change ignored", data_out, 8'h96);
        chk("R10", "no parity error after change", parity_err, 0);
        clear_dr();
        send_frame(8'h0D, 5, 1, par_of(8'h0D, 5, 1), 1'b1, 64, 0);
        chk("R10", "new length applies to next char", data_out, 8'h0D);
        clear_dr();
    endtask

    task automatic t_back_to_back;
        set_ctrl(2'b11, 1'b0, 1'b1);
        send_frame(8'h0F, 8, 1, par_of(8'h0F, 8, 1), 1'b1, 56, 0);
        chk("R11", "first of pair", data_out, 8'h0F);
        clear_dr();
        send_frame(8'hF0, 8, 1, par_of(8'hF0, 8, 1), 1'b1, 64, 0);
        chk("R11", "second of pair", data_out, 8'hF0);
        chk("R11", "second ready", data_ready, 1);
        chk("R11", "no framing error on pair", framing_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_in = 1'b1; ctrl_load = 1'b0; len_sel = 2'b11;
        par_inhibit = 1'b0; par_even = 1'b1; dr_clr_n = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_clear();
        t_lengths();
        t_parity();
        t_inhibit();
        t_framing();
        t_overrun();
        t_glitch();
        t_midchange();
        t_back_to_back();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule